// File: doc/BRIEF.md
# Sticky Error Status Register with Terminal Flag

This block gathers error indications from hardware sources into one status word. Each source drives a one-cycle pulse on its own bit of `err_pulse`. The matching bit of the register goes high and stays high. While any bit is high, the block holds `term_flag` high. On the cycle where `term_flag` first goes high, the block emits a one-cycle `intf_rst_req` pulse, which asks the surrounding interface logic to reset.

The status word has sixteen bits. Only the low eight bits are storage; the upper eight bits always read as zero. `rd_data` shows the current contents at all times. A consumer reads it in the cycle where it raises `rd_en`. At the clock edge that ends that cycle, the register is cleared. An error pulse that arrives in that same cycle is written into the register after the clear, so it is not lost.

The reset is synchronous and active low. It empties the register and drops the terminal flag.

Top module: `err_status_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register is cleared. After that edge `rd_data` is 0x0000, `term_flag` is 0 and `intf_rst_req` is 0.
- R2: Bit i of `err_pulse` (i = 0..7) being high at a clock edge sets bit i of `rd_data` after that edge. The bit stays set until a read or a reset.
- R3: Bits 15..8 of `rd_data` always read as zero.
- R4: `term_flag` is 1 exactly when at least one of bits 7..0 of `rd_data` is 1.
- R5: `rd_en` high at a clock edge, with no error pulse present, leaves `rd_data` at 0x0000 after that edge.
- R6: In the cycle where `rd_en` is high, `rd_data` shows the contents as they were before the clear.
- R7: An error pulse present at the same edge as a read is held in the register after the clear. After that edge `rd_data` equals the pulse pattern.
- R8: `intf_rst_req` is high for exactly one cycle: the first cycle in which `term_flag` is high after having been low.
- R9: While `term_flag` stays high, further error pulses, and reads that are followed by a same-cycle error, cause no further `intf_rst_req` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse | input | 8 | One bit per error source; a high bit sets the matching sticky bit |
| rd_en | input | 1 | Read strobe; the register clears at the end of this cycle |
| rd_data | output | 16 | Current status word, upper byte zero |
| term_flag | output | 1 | High while any status bit is set |
| intf_rst_req | output | 1 | One-cycle interface-reset request on the rise of `term_flag` |

## Verification
The assertions check the following on every cycle:
- the upper byte stays zero;
- `term_flag` agrees with the stored bits;
- a set bit survives any cycle without a read;
- the content after a read equals the error pattern that was present at that read;
- the reset request is a single cycle that coincides with each rise of the flag.

Only the bench scenarios can show the following:
- that the value a consumer reads in the strobe cycle is the pre-clear contents;
- that accumulation across several sources yields the exact expected words;
- that a reset in the middle of activity empties a full register;
- that a read colliding with an error keeps the flag up without a second request.

// File: rtl/esr_pkg.sv
// Package: shared sizing for the sticky error status register.
// Assumes the status word is at least as wide as the error field.
package esr_pkg;
    localparam int unsigned ESR_WORD_W = 16;
    localparam int unsigned ESR_ERR_W  = 8;
endpackage

// File: rtl/esr_sticky_bank.sv
// Module: esr_sticky_bank
// A row of sticky bits. A set pulse on a bit latches it high. A clear
// empties the row, but a set pulse in the same cycle as the clear wins,
// so that an error is never dropped.
// Assumes: set_i pulses are synchronous to clk; reset is synchronous active low.
module esr_sticky_bank #(
    parameter int unsigned ERR_W = esr_pkg::ESR_ERR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_i,
    input  logic             clr_i,
    output logic [ERR_W-1:0] bits_o
);

    for (genvar g = 0; g < ERR_W; g++) begin : g_cell
        logic held_q;

        // Purpose: hold one error bit until cleared or reset; a set beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= 1'b0;
            end else if (set_i[g]) begin
                held_q <= 1'b1;
            end else if (clr_i) begin
                held_q <= 1'b0;
            end
        end

        assign bits_o[g] = held_q;
    end

endmodule

// File: rtl/esr_flag_edge.sv
// Module: esr_flag_edge
// Reduces the sticky bits to a terminal flag. It also produces a
// one-cycle request in the first cycle in which the flag is high after
// having been low.
// Assumes: bits_i comes straight from registers; reset is synchronous active low.
module esr_flag_edge #(
    parameter int unsigned ERR_W = esr_pkg::ESR_ERR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] bits_i,
    output logic             flag_o,
    output logic             rise_o
);

    logic flag_prev_q;

    // Purpose: terminal flag is the OR of all stored error bits.
    always_comb begin
        flag_o = |bits_i;
    end

    // Purpose: remember last cycle's flag to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_prev_q <= 1'b0;
        end else begin
            flag_prev_q <= flag_o;
        end
    end

    // Purpose: request lasts only the first cycle of a high flag.
    always_comb begin
        rise_o = flag_o & ~flag_prev_q;
    end

endmodule

// File: rtl/esr_read_mux.sv
// Module: esr_read_mux
// Places the error field in the low end of the status word and fills
// the unused upper bits with zeros.
// Assumes: WORD_W >= ERR_W.
module esr_read_mux #(
    parameter int unsigned WORD_W = esr_pkg::ESR_WORD_W,
    parameter int unsigned ERR_W  = esr_pkg::ESR_ERR_W
) (
    input  logic [ERR_W-1:0]  bits_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned PAD_W = WORD_W - ERR_W;

    if (PAD_W > 0) begin : g_pad
        // Purpose: zero-extend the stored bits to the word width.
        always_comb begin
            word_o = {{PAD_W{1'b0}}, bits_i};
        end
    end else begin : g_nopad
        // Purpose: word and field have equal width; pass through.
        always_comb begin
            word_o = bits_i;
        end
    end

endmodule

// File: rtl/err_status_reg.sv
// Module: err_status_reg (top)
// Sticky, clear-on-read error status word with a terminal flag and a
// one-cycle interface-reset request on the rise of that flag.
// Assumes: rd_en and err_pulse are synchronous to clk; rst_n is a
// synchronous active-low reset.
module err_status_reg #(
    parameter int unsigned WORD_W = esr_pkg::ESR_WORD_W,
    parameter int unsigned ERR_W  = esr_pkg::ESR_ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  err_pulse,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              term_flag,
    output logic              intf_rst_req
);

    logic [ERR_W-1:0] stat_bits;

    esr_sticky_bank #(.ERR_W(ERR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_pulse),
        .clr_i  (rd_en),
        .bits_o (stat_bits)
    );

    esr_flag_edge #(.ERR_W(ERR_W)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .bits_i (stat_bits),
        .flag_o (term_flag),
        .rise_o (intf_rst_req)
    );

    esr_read_mux #(.WORD_W(WORD_W), .ERR_W(ERR_W)) u_rmux (
        .bits_i (stat_bits),
        .word_o (rd_data)
    );

endmodule

// File: rtl/esr_checker.sv
// Module: esr_checker
// Port-level properties of err_status_reg. It is attached to the top
// module by the bind statement at the end of this file.
module esr_checker #(
    parameter int unsigned WORD_W = esr_pkg::ESR_WORD_W,
    parameter int unsigned ERR_W  = esr_pkg::ESR_ERR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ERR_W-1:0]  err_pulse,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_data,
    input logic              term_flag,
    input logic              intf_rst_req
);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-1:ERR_W] == '0);

    a_r4_flag_tracks_bits: assert property (@(posedge clk) disable iff (!rst_n)
        term_flag == (rd_data[ERR_W-1:0] != '0));

    a_r2_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((rd_data[ERR_W-1:0] & $past(rd_data[ERR_W-1:0]))
                    == $past(rd_data[ERR_W-1:0])));

    a_r7_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data[ERR_W-1:0] == $past(err_pulse));

    a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        intf_rst_req |=> !intf_rst_req);

    a_r8_req_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_flag) |-> intf_rst_req);

    a_r9_req_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        intf_rst_req |-> term_flag);

endmodule

bind err_status_reg esr_checker #(.WORD_W(WORD_W), .ERR_W(ERR_W)) u_esr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_pulse    (err_pulse),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .term_flag    (term_flag),
    .intf_rst_req (intf_rst_req)
);

// File: tb/test_err_status_reg.sv
// Bench for err_status_reg.
// Inputs change on the falling edge of the clock. Outputs are sampled
// on the following falling edge, which is after the rising edge that
// acts on them.
module test_err_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  err_pulse = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        term_flag;
    logic        intf_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    err_status_reg i_err_status_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_pulse    (err_pulse),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .term_flag    (term_flag),
        .intf_rst_req (intf_rst_req)
    );

    // Vector layout: {rd, err[7:0], exp_low[7:0], exp_flag, exp_req}.
    // The expected values hold after the edge that applies the inputs.
    localparam int NVEC = 13;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b0},  // idle
        {1'b0, 8'h01, 8'h01, 1'b1, 1'b1},  // R2 R8 first error, flag rises
        {1'b0, 8'h00, 8'h01, 1'b1, 1'b0},  // R2 R8 sticky, pulse ends
        {1'b0, 8'h80, 8'h81, 1'b1, 1'b0},  // R9 more errors, no new req
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0},  // R5 read clears
        {1'b0, 8'h24, 8'h24, 1'b1, 1'b1},  // R8 rises again
        {1'b1, 8'h02, 8'h02, 1'b1, 1'b0},  // R7 R9 read with error
        {1'b0, 8'h00, 8'h02, 1'b1, 1'b0},  // R2 kept
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0},  // R5
        {1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R2 all sources
        {1'b0, 8'h00, 8'hFF, 1'b1, 1'b0},  // R4
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0},  // R5
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0}   // R5 read when empty
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic rd, input logic [7:0] err);
        rd_en = rd;
        err_pulse = err;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 data", rd_data, 16'h0000);
        check("R1 flag", {15'd0, term_flag}, 16'd0);
        check("R1 req", {15'd0, intf_rst_req}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][18], VEC[i][17:10]);
            check($sformatf("R2/R5/R7 vec%0d data", i), rd_data, {8'h00, VEC[i][9:2]});
            check($sformatf("R3 vec%0d upper", i), {8'h00, rd_data[15:8]}, 16'h0000);
            check($sformatf("R4 vec%0d flag", i), {15'd0, term_flag}, {15'd0, VEC[i][1]});
            check($sformatf("R8/R9 vec%0d req", i), {15'd0, intf_rst_req}, {15'd0, VEC[i][0]});
        end

        // R6: during the read cycle, the data shows the pre-clear contents
        step(1'b0, 8'h5A);
        rd_en = 1'b1;
        err_pulse = 8'h00;
        #1;
        check("R6 read value", rd_data, 16'h005A);
        @(negedge clk);
        check("R6 cleared after read", rd_data, 16'h0000);

        // R1: reset in the middle of activity empties a full register
        step(1'b0, 8'hC3);
        rst_n = 1'b0;
        step(1'b0, 8'h00);
        check("R1 mid reset data", rd_data, 16'h0000);
        check("R1 mid reset flag", {15'd0, term_flag}, 16'd0);
        rst_n = 1'b1;
        step(1'b0, 8'h10);
        check("R8 req after reset", {15'd0, intf_rst_req}, 16'd1);
        check("R2 bit4 set", rd_data, 16'h0010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule